// File: doc/BRIEF.md
# Synchronized Clock Enable Divider

This block takes one of two incoming clocks and fans it out to two output banks. Bank A carries the chosen clock at its own rate. Bank B carries it divided by two. Each bank drives two identical pairs, and each pair has a true output and a complement output. The select input is treated as static, so it only changes while the block is held in reset or is idle.

The clock enable may arrive from any domain. It is brought into the selected clock domain by two rising-edge flops. It is then retimed on a falling edge, and the outputs are gated with this last version. Because the gate moves only while the clock is low, an output pulse is never cut short. The master reset is active high. It forces every output to its idle state at once. Its release is synchronized to the selected clock, so the divider never starts on a partial cycle.

Top module: `clk_fanout_div`

## Requirements
- R1: When `src_sel` is 1, the outputs follow `clk_src1`. When `src_sel` is 0, they follow `clk_src0`.
- R2: While enabled, every bank A true output is high in the high phase of the selected clock and low in its low phase.
- R3: While enabled, bank B has a period of exactly two selected-clock periods. Its first high phase starts on the first rising edge after the enable takes effect.
- R4: While `mst_rst` is 1, every true output is 0 and every complement output is 1, with no clock needed and whatever `clk_en` and `src_sel` are.
- R5: When `mst_rst` falls just after a rising edge while `clk_en` is held at 1, the true outputs stay low through the next four rising edges. Bank A is first high after the fifth rising edge.
- R6: While the effective enable is 0, every true output is 0 and every complement output is 1.
- R7: An enable change made just after rising edge k takes effect at the falling edge of cycle k+2. So cycle k+3 is the first high phase affected.
- R8: When the enable toggles at random times, no high pulse on a bank A or bank B true output is shorter than half a selected-clock period.
- R9: The two true outputs of a bank are always equal, and each complement output is the inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src0 | input | 1 | First clock source |
| clk_src1 | input | 1 | Second clock source |
| src_sel | input | 1 | Source select, 1 picks clk_src1 |
| clk_en | input | 1 | Asynchronous output enable |
| mst_rst | input | 1 | Active-high master reset |
| qa0 | output | 1 | Bank A pair 0, true |
| qa0_n | output | 1 | Bank A pair 0, complement |
| qa1 | output | 1 | Bank A pair 1, true |
| qa1_n | output | 1 | Bank A pair 1, complement |
| qb0 | output | 1 | Bank B pair 0, true |
| qb0_n | output | 1 | Bank B pair 0, complement |
| qb1 | output | 1 | Bank B pair 1, true |
| qb1_n | output | 1 | Bank B pair 1, complement |

## Verification
A wrong synchronizer depth shows up at once: bank A's first or last pulse after an enable change lands one cycle early or late. If the divide-by-two flop is not cleared while the block is disabled, bank B comes back in the wrong phase on the very first enabled cycle. A gate that is updated on the wrong edge shows up as a high pulse shorter than half a period within a few random enable toggles. A release that is not synchronized lets bank A restart before the fifth rising edge after reset falls.

// File: rtl/clk_fanout_div.sv
module clk_fanout_div (
  input  logic clk_src0,
  input  logic clk_src1,
  input  logic src_sel,
  input  logic clk_en,
  input  logic mst_rst,
  output logic qa0,
  output logic qa0_n,
  output logic qa1,
  output logic qa1_n,
  output logic qb0,
  output logic qb0_n,
  output logic qb1,
  output logic qb1_n
);

  logic sel_clk;
  logic rel_q1, rel_q2;
  logic en_meta, en_sync, en_gate;
  logic div_q;
  logic bank_a, bank_b;

  assign sel_clk = src_sel ? clk_src1 : clk_src0;

  always_ff @(posedge sel_clk or posedge mst_rst)
    if (mst_rst) begin
      rel_q1 <= 1'b0;
      rel_q2 <= 1'b0;
    end else begin
      rel_q1 <= 1'b1;
      rel_q2 <= rel_q1;
    end

  always_ff @(posedge sel_clk or negedge rel_q2)
    if (!rel_q2) begin
      en_meta <= 1'b0;
      en_sync <= 1'b0;
    end else begin
      en_meta <= clk_en;
      en_sync <= en_meta;
    end

  always_ff @(negedge sel_clk or negedge rel_q2)
    if (!rel_q2) en_gate <= 1'b0;
    else         en_gate <= en_sync;

  always_ff @(posedge sel_clk or negedge rel_q2)
    if (!rel_q2)      div_q <= 1'b0;
    else if (!en_gate) div_q <= 1'b0;
    else              div_q <= ~div_q;

  assign bank_a = sel_clk & en_gate;
  assign bank_b = div_q & en_gate;

  assign qa0   = bank_a;
  assign qa1   = bank_a;
  assign qa0_n = ~bank_a;
  assign qa1_n = ~bank_a;
  assign qb0   = bank_b;
  assign qb1   = bank_b;
  assign qb0_n = ~bank_b;
  assign qb1_n = ~bank_b;

  assert_reset_forced_R4: assert property (@(posedge sel_clk)
    mst_rst |-> (!qa0 && qa0_n && !qb0 && qb0_n));

  assert_release_order_R5: assert property (@(posedge sel_clk) disable iff (mst_rst)
    $rose(rel_q2) |-> $past(rel_q1));

  assert_div_idle_R6: assert property (@(posedge sel_clk) disable iff (!rel_q2)
    (!en_gate && $past(!en_gate)) |-> !div_q);

  assert_div_start_R3: assert property (@(posedge sel_clk) disable iff (!rel_q2)
    $rose(en_gate) |-> !div_q);

  assert_sync_depth_R7: assert property (@(posedge sel_clk) disable iff (!rel_q2)
    $rose(en_gate) |-> $past(en_meta));

endmodule

// File: tb/tb_clk_fanout_div.sv
`timescale 1ns/1ps
module tb_clk_fanout_div;
  localparam real CLK_PERIOD = 10.0;
  localparam real ALT_PERIOD = 14.0;

  logic clk_a = 1'b0, clk_b = 1'b0;
  logic src_sel = 1'b0, clk_en = 1'b0, mst_rst = 1'b1;
  logic qa0, qa0_n, qa1, qa1_n, qb0, qb0_n, qb1, qb1_n;

  clk_fanout_div dut (
    .clk_src0(clk_a), .clk_src1(clk_b), .src_sel(src_sel), .clk_en(clk_en),
    .mst_rst(mst_rst), .qa0(qa0), .qa0_n(qa0_n), .qa1(qa1), .qa1_n(qa1_n),
    .qb0(qb0), .qb0_n(qb0_n), .qb1(qb1), .qb1_n(qb1_n));

  always #(CLK_PERIOD/2) clk_a = ~clk_a;
  always #(ALT_PERIOD/2) clk_b = ~clk_b;

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic check_forced(input string req);
    check_eq(req, "forced outputs", {qa0, qa1, qb0, qb1, qa0_n, qa1_n, qb0_n, qb1_n}, 8'b0000_1111);
  endtask

  task automatic check_pairs();
    check_eq("R9", "pair match", {qa1, qb1, ~qa0_n, ~qa1_n, ~qb0_n, ~qb1_n},
             {qa0, qb0, qa0, qa0, qb0, qb0});
  endtask

  // scoreboard: driver pushes the enable value of each cycle, monitor models the outputs
  bit exp_q[$];
  bit h0 = 0, h1 = 0, h2 = 0, h3 = 0, h4 = 0, div_m = 0;

  task automatic drive_cycle(input bit v);
    @(posedge clk_a);
    #1;
    clk_en = v;
    exp_q.push_back(v);
  endtask

  always begin
    @(posedge clk_a);
    #(CLK_PERIOD/4);
    if (exp_q.size() != 0) begin
      h4 = h3; h3 = h2; h2 = h1; h1 = h0; h0 = exp_q.pop_front();
      div_m = h3 ? ~div_m : 1'b0;
      check_eq((h3 != h4) ? "R7" : (h3 ? "R2" : "R6"), "qa0 high phase", qa0, h3);
      check_eq("R3", "qb0 high phase", qb0, div_m & h3);
      check_pairs();
      @(negedge clk_a);
      #(CLK_PERIOD/4);
      check_eq("R2", "qa0 low phase", qa0, 0);
      check_eq((h3 != h2) ? "R7" : "R3", "qb0 low phase", qb0, div_m & h2);
      check_pairs();
    end
  end

  // pulse width and period monitors
  realtime ta_r = 0, tb_r = 0, ta_prev = 0, tb_prev = 0;
  bit pw_on = 0, a_per_on = 0, a_arm = 0, b_per_on = 0, b_arm = 0;
  int a_exp_ps = 10000, b_exp_ps = 20000;

  always @(posedge qa0) begin
    ta_r = $realtime;
    if (a_per_on && a_arm) check_eq("R1", "qa0 period ps", int'(($realtime - ta_prev) * 1000.0), a_exp_ps);
    a_arm = a_per_on;
    ta_prev = $realtime;
  end
  always @(negedge qa0)
    if (pw_on) check(($realtime - ta_r) >= CLK_PERIOD/2 - 0.001, "R8", "qa0 pulse ps",
                     int'(($realtime - ta_r) * 1000.0), int'(CLK_PERIOD * 500.0));
  always @(posedge qb0) begin
    tb_r = $realtime;
    if (b_per_on && b_arm) check_eq("R3", "qb0 period ps", int'(($realtime - tb_prev) * 1000.0), b_exp_ps);
    b_arm = b_per_on;
    tb_prev = $realtime;
  end
  always @(negedge qb0)
    if (pw_on) check(($realtime - tb_r) >= CLK_PERIOD/2 - 0.001, "R8", "qb0 pulse ps",
                     int'(($realtime - tb_r) * 1000.0), int'(CLK_PERIOD * 500.0));

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    failures++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    finish_run();
  end

  initial begin
    #1;
    check_forced("R4");
    repeat (3) @(posedge clk_a);
    #1;
    check_forced("R4");
    mst_rst = 1'b0;
    repeat (4) @(posedge clk_a);

    // scoreboard session: steady, short and single-cycle enables
    repeat (4) drive_cycle(1'b0);
    repeat (12) drive_cycle(1'b1);
    repeat (6) drive_cycle(1'b0);
    repeat (3) drive_cycle(1'b1);
    repeat (6) drive_cycle(1'b0);
    drive_cycle(1'b1);
    repeat (6) drive_cycle(1'b0);
    repeat (2) drive_cycle(1'b1);
    repeat (6) drive_cycle(1'b0);
    @(posedge clk_a);

    // R4 mid-run reset while enabled, R5 synchronized release
    @(posedge clk_a); #1 clk_en = 1'b1;
    repeat (5) @(posedge clk_a);
    #2;
    check_eq("R2", "qa0 enabled", qa0, 1);
    mst_rst = 1'b1;
    #0.5;
    check_forced("R4");
    repeat (3) begin
      @(posedge clk_a); #(CLK_PERIOD/4);
      check_forced("R4");
    end
    src_sel = 1'b1;
    #3;
    check_forced("R4");
    src_sel = 1'b0;
    @(posedge clk_a); #1 mst_rst = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk_a); #(CLK_PERIOD/4);
      check_eq("R5", "qa0 after release", qa0, (k == 5) ? 1 : 0);
    end

    // R3 bank B period, R1 bank A period on source 0
    a_exp_ps = 10000; b_exp_ps = 20000;
    a_per_on = 1; b_per_on = 1;
    repeat (10) @(posedge clk_a);
    a_per_on = 0; b_per_on = 0;
    #1;

    // R1 second source
    mst_rst = 1'b1;
    src_sel = 1'b1;
    @(posedge clk_b); #1 mst_rst = 1'b0;
    repeat (8) @(posedge clk_b);
    a_exp_ps = 14000; b_exp_ps = 28000;
    a_per_on = 1; b_per_on = 1;
    repeat (3) begin
      @(posedge clk_b); #1;
      check_eq("R1", "qa0 on source 1 high", qa0, 1);
      @(negedge clk_b); #1;
      check_eq("R1", "qa0 on source 1 low", qa0, 0);
    end
    repeat (6) @(posedge clk_b);
    a_per_on = 0; b_per_on = 0;

    mst_rst = 1'b1;
    clk_en = 1'b0;
    src_sel = 1'b0;
    @(posedge clk_a); #1 mst_rst = 1'b0;
    repeat (4) @(posedge clk_a);

    // R8 asynchronous enable toggling
    pw_on = 1;
    for (int i = 0; i < 300; i++) begin
      #($urandom_range(100, 40000) / 1000.0);
      clk_en = ~clk_en;
    end
    clk_en = 1'b0;
    repeat (6) @(posedge clk_a);
    pw_on = 0;
    #1;
    check_forced("R6");

    finish_run();
  end
endmodule